// File: doc/BRIEF.md
# IR Transmit Modulator with Envelope Output

This block produces the infrared transmit waveform. A carrier generator counts pulses of a divided IR clock enable and makes a square wave. The high and low durations are programmed separately. A data bit and a polarity bit together form the envelope. In standard operation the envelope gates the carrier onto the main transmit pin. The polarity bit sets both the idle level and the sense of that pin.

A 2-bit mode field can also send the envelope to a second pin on its own. Two settings of this field change the main pin:
- In one, the main pin keeps the gated carrier.
- In the other, the main pin carries the carrier continuously, with no gating. An external stage can then do the gating.

The data bit, the polarity bit and the mode field are taken only while transmit is off, or at the end of a carrier period. Because of this, a change made by software mid-period never cuts a carrier pulse short.

Top module: `irtx_mod`

## Requirements
- R1: While `tx_en` is low (and during reset), both `tx_out` and `env_out` equal the live `tx_pol` input. The carrier restarts at the start of its high phase when `tx_en` next rises.
- R2: The carrier is high for `hi_len` pulses of `irclk_en` and then low for `lo_len` pulses, and this repeats. Cycles without `irclk_en` leave it unchanged. With k enables counted since `tx_en` rose, the carrier is high when (k mod P) < H, where P = H + L.
- R3: A programmed duration of 0 is treated as a duration of 1.
- R4: The envelope equals data XOR polarity. With polarity 1, the sense of the data bit is inverted on every pin.
- R5: Mode 2'b00 and mode 2'b11 are both standard modulation. In these modes `tx_out` = pol XOR (data AND carrier), and `env_out` is held at 0.
- R6: In mode 2'b01, `env_out` carries the envelope, and `tx_out` keeps the standard gated output.
- R7: In mode 2'b10, `env_out` carries the envelope, and `tx_out` = pol XOR carrier regardless of the data bit.
- R8: While enabled, the data, polarity and mode inputs are taken only at the clock edge that ends a low phase. That edge is the one where k reaches a multiple of P. A change made earlier in the period takes effect exactly at that edge.
- R9: While `tx_en` stays high, `tx_out` changes only in a cycle where the carrier also changes, so no pulse shorter than a carrier phase appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_en | input | 1 | Transmit enable; low forces the idle level |
| irclk_en | input | 1 | Divided IR clock enable, one pulse per carrier count |
| hi_len | input | CW | Carrier high duration in enables (0 acts as 1) |
| lo_len | input | CW | Carrier low duration in enables (0 acts as 1) |
| tx_data | input | 1 | Transmit data bit |
| tx_pol | input | 1 | Transmit polarity bit and idle level |
| env_mode | input | 2 | Envelope mode: 00/11 standard, 01 split, 10 split with ungated carrier |
| tx_out | output | 1 | Main IR transmit pin |
| env_out | output | 1 | Separate envelope pin |

## Verification
A settings update and a carrier edge can fall in the same cycle, because the update is timed to happen exactly when the low phase wraps back to high. The bench provokes this in two ways. In one case it changes data, polarity and mode several enables before the boundary. In the other it makes the change on the last low sample, so the new settings are taken at the same edge that raises the carrier. Each sample is judged against a period count kept in the bench, so the new pin levels must appear at the wrap sample and not one cycle early or late.

// File: rtl/irtx_pkg.sv
package irtx_pkg;

  typedef enum logic [1:0] {
    ENV_STD_A = 2'b00,
    ENV_SPLIT = 2'b01,
    ENV_RAW   = 2'b10,
    ENV_STD_B = 2'b11
  } env_mode_e;

  typedef struct packed {
    logic      data;
    logic      pol;
    env_mode_e mode;
  } tx_cfg_t;

  // Programmed duration with zero promoted to one count.
  function automatic logic [31:0] eff_len(input logic [31:0] n);
    return (n == 32'd0) ? 32'd1 : n;
  endfunction

  // Pin levels {tx, env} for a committed setting and carrier level.
  function automatic logic [1:0] pin_levels(input env_mode_e m, input logic d,
                                            input logic p, input logic c);
    logic env, gated, raw;
    env   = d ^ p;
    gated = p ^ (d & c);
    raw   = p ^ c;
    case (m)
      ENV_SPLIT: return {gated, env};
      ENV_RAW:   return {raw, env};
      default:   return {gated, 1'b0};
    endcase
  endfunction

endpackage

// File: rtl/irtx_carrier.sv
module irtx_carrier #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          tick,
  input  logic [CW-1:0] hi_len,
  input  logic [CW-1:0] lo_len,
  output logic          carrier,
  output logic          period_end
);
  logic [CW-1:0] cnt;
  logic          ph;
  logic [CW-1:0] hi_last, lo_last, lim;
  logic          phase_end;

  assign hi_last    = CW'(irtx_pkg::eff_len(32'(hi_len)) - 32'd1);
  assign lo_last    = CW'(irtx_pkg::eff_len(32'(lo_len)) - 32'd1);
  assign lim        = ph ? hi_last : lo_last;
  assign phase_end  = run & tick & (cnt == lim);
  assign period_end = phase_end & ~ph;
  assign carrier    = ph;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph  <= 1'b1;
      cnt <= '0;
    end else if (!run) begin
      ph  <= 1'b1;
      cnt <= '0;
    end else if (tick) begin
      if (cnt == lim) begin
        cnt <= '0;
        ph  <= ~ph;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  // R2: no enable pulse, no movement of the generator
  p_hold_without_tick_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !tick) |=> ($stable(ph) && $stable(cnt)));

  // R2: the end of a low phase always returns to the high phase
  p_wrap_to_high_r2: assert property (@(posedge clk) disable iff (!rst_n)
    period_end |=> (ph && cnt == '0));

endmodule

// File: rtl/irtx_cfg_hold.sv
module irtx_cfg_hold (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              period_end,
  input  logic              data_in,
  input  logic              pol_in,
  input  logic [1:0]        mode_in,
  output irtx_pkg::tx_cfg_t cfg_q,
  output logic              cfg_load
);
  assign cfg_load = ~run | period_end;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '{data: 1'b0, pol: 1'b0, mode: irtx_pkg::ENV_STD_A};
    end else if (cfg_load) begin
      cfg_q <= '{data: data_in, pol: pol_in,
                 mode: irtx_pkg::env_mode_e'(mode_in)};
    end
  end

  // R8: mid-period the committed settings cannot move
  p_cfg_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !period_end) |=> $stable(cfg_q));

endmodule

// File: rtl/irtx_pinmux.sv
module irtx_pinmux (
  input  logic              run,
  input  logic              carrier,
  input  logic              live_pol,
  input  irtx_pkg::tx_cfg_t cfg,
  output logic              tx_out,
  output logic              env_out
);
  logic [1:0] lvl;

  assign lvl     = irtx_pkg::pin_levels(cfg.mode, cfg.data, cfg.pol, carrier);
  assign tx_out  = run ? lvl[1] : live_pol;
  assign env_out = run ? lvl[0] : live_pol;

endmodule

// File: rtl/irtx_mod.sv
module irtx_mod #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tx_en,
  input  logic          irclk_en,
  input  logic [CW-1:0] hi_len,
  input  logic [CW-1:0] lo_len,
  input  logic          tx_data,
  input  logic          tx_pol,
  input  logic [1:0]    env_mode,
  output logic          tx_out,
  output logic          env_out
);
  logic              carrier;
  logic              period_end;
  logic              cfg_load;
  irtx_pkg::tx_cfg_t cfg_q;

  irtx_carrier #(.CW(CW)) u_carrier (
    .clk        (clk),
    .rst_n      (rst_n),
    .run        (tx_en),
    .tick       (irclk_en),
    .hi_len     (hi_len),
    .lo_len     (lo_len),
    .carrier    (carrier),
    .period_end (period_end)
  );

  irtx_cfg_hold u_cfg (
    .clk        (clk),
    .rst_n      (rst_n),
    .run        (tx_en),
    .period_end (period_end),
    .data_in    (tx_data),
    .pol_in     (tx_pol),
    .mode_in    (env_mode),
    .cfg_q      (cfg_q),
    .cfg_load   (cfg_load)
  );

  irtx_pinmux u_mux (
    .run      (tx_en),
    .carrier  (carrier),
    .live_pol (tx_pol),
    .cfg      (cfg_q),
    .tx_out   (tx_out),
    .env_out  (env_out)
  );

  // R1: disabled pins rest at the polarity level
  p_idle_pins_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_en |-> (tx_out == tx_pol && env_out == tx_pol));

  // R9: a main-pin change while running always coincides with a carrier edge
  p_no_runt_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_en && $past(tx_en) && tx_out != $past(tx_out)) |-> (carrier != $past(carrier)));

  // R8: a settings update while running only happens on a low-to-high carrier edge
  p_load_on_wrap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_en && cfg_load) |=> carrier);

endmodule

// File: tb/irtx_mod_tb.sv
module irtx_mod_tb;
  localparam int CW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          tx_en = 1'b0;
  logic          irclk_en = 1'b0;
  logic [CW-1:0] hi_len = 8'd3;
  logic [CW-1:0] lo_len = 8'd2;
  logic          tx_data = 1'b0;
  logic          tx_pol = 1'b0;
  logic [1:0]    env_mode = 2'b00;
  wire           tx_out;
  wire           env_out;

  int  vecs = 0;
  int  errs = 0;
  int  k = 0;
  bit  m_data = 1'b0, m_pol = 1'b0;
  bit  [1:0] m_mode = 2'b00;
  bit  done = 1'b0;

  always #2.5 clk = ~clk;

  irtx_mod #(.CW(CW)) u_dut (
    .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .irclk_en(irclk_en),
    .hi_len(hi_len), .lo_len(lo_len), .tx_data(tx_data), .tx_pol(tx_pol),
    .env_mode(env_mode), .tx_out(tx_out), .env_out(env_out)
  );

  function automatic int eff(input int n);
    return (n == 0) ? 1 : n;
  endfunction

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    vecs++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s %s at k=%0d: actual %b expected %b", req, what, k, act, exp);
    end
  endtask

  task automatic commit();
    m_data = tx_data;
    m_pol  = tx_pol;
    m_mode = env_mode;
  endtask

  // One clock with the given enable, then compare both pins with the bench model.
  task automatic step(input bit en, input string req);
    bit car, e_tx, e_env;
    int h, p;
    irclk_en = en;
    @(posedge clk);
    h = eff(int'(hi_len));
    p = h + eff(int'(lo_len));
    if (!tx_en) begin
      k = 0;
      commit();
    end else if (en) begin
      k++;
      if (k % p == 0) commit();
    end
    #1;
    if (!tx_en) begin
      e_tx  = tx_pol;
      e_env = tx_pol;
    end else begin
      car = ((k % p) < h);
      if (m_mode == 2'b10) e_tx = m_pol ? !car : car;
      else                 e_tx = m_data ? (m_pol ? !car : car) : m_pol;
      e_env = (m_mode == 2'b01 || m_mode == 2'b10) ? (m_data ^ m_pol) : 1'b0;
    end
    chk(req, "tx_out", tx_out, e_tx);
    chk(req, "env_out", env_out, e_env);
  endtask

  task automatic setup(input int h, input int l, input bit d, input bit p, input bit [1:0] m);
    tx_en    = 1'b0;
    hi_len   = CW'(h);
    lo_len   = CW'(l);
    tx_data  = d;
    tx_pol   = p;
    env_mode = m;
    step(1'b1, "R1");
  endtask

  task automatic t_reset();
    #1;
    chk("R1", "tx_out in reset", tx_out, 1'b0);
    chk("R1", "env_out in reset", env_out, 1'b0);
    tx_pol = 1'b1;
    #1;
    chk("R1", "tx_out idle pol1", tx_out, 1'b1);
    chk("R1", "env_out idle pol1", env_out, 1'b1);
    tx_pol = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    step(1'b1, "R1");
    step(1'b1, "R1");
  endtask

  task automatic t_standard();
    setup(3, 2, 1'b1, 1'b0, 2'b00);
    tx_en = 1'b1;
    repeat (15) step(1'b1, "R5");
    tx_en = 1'b0;
    step(1'b1, "R1");
  endtask

  task automatic t_polarity();
    setup(3, 2, 1'b1, 1'b1, 2'b11);
    tx_en = 1'b1;
    repeat (12) step(1'b1, "R4");
    setup(3, 2, 1'b0, 1'b1, 2'b11);
    tx_en = 1'b1;
    repeat (8) step(1'b1, "R5");
  endtask

  task automatic t_split();
    setup(2, 3, 1'b1, 1'b0, 2'b01);
    tx_en = 1'b1;
    repeat (12) step(1'b1, "R6");
    setup(2, 3, 1'b1, 1'b1, 2'b01);
    tx_en = 1'b1;
    repeat (8) step(1'b1, "R6");
  endtask

  task automatic t_raw();
    setup(2, 2, 1'b0, 1'b1, 2'b10);
    tx_en = 1'b1;
    repeat (12) step(1'b1, "R7");
    setup(2, 2, 1'b0, 1'b0, 2'b10);
    tx_en = 1'b1;
    repeat (8) step(1'b1, "R7");
  endtask

  task automatic t_zero_len();
    setup(0, 0, 1'b1, 1'b0, 2'b00);
    tx_en = 1'b1;
    repeat (10) step(1'b1, "R3");
  endtask

  task automatic t_gated_tick();
    setup(2, 1, 1'b1, 1'b0, 2'b01);
    tx_en = 1'b1;
    for (int i = 0; i < 30; i++) step(i % 3 == 0, "R2");
  endtask

  // Settings changed early in a period, then on the last low sample.
  task automatic t_deferred();
    setup(4, 3, 1'b1, 1'b0, 2'b00);
    tx_en = 1'b1;
    step(1'b1, "R8");
    step(1'b1, "R8");
    tx_data  = 1'b0;
    tx_pol   = 1'b1;
    env_mode = 2'b01;
    repeat (11) step(1'b1, "R8");
    tx_data  = 1'b1;
    tx_pol   = 1'b0;
    env_mode = 2'b10;
    repeat (9) step(1'b1, "R9");
  endtask

  task automatic t_disable_mid();
    setup(3, 3, 1'b1, 1'b0, 2'b00);
    tx_en = 1'b1;
    repeat (4) step(1'b1, "R1");
    tx_en = 1'b0;
    repeat (2) step(1'b1, "R1");
    tx_en = 1'b1;
    repeat (7) step(1'b1, "R1");
    tx_en = 1'b0;
    step(1'b1, "R1");
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  endtask

  initial begin
    t_reset();
    t_standard();
    t_polarity();
    t_split();
    t_raw();
    t_zero_len();
    t_gated_tick();
    t_deferred();
    t_disable_mid();
    done = 1'b1;
    finish_run();
  end

  initial begin
    #1000000;
    if (!done) begin
      errs++;
      $display("FAIL watchdog: actual hung expected finished");
      finish_run();
    end
  end

endmodule